// File: doc/BRIEF.md
# System Reset and Stop-Recovery Controller

This block merges every reset cause of a small microcontroller into a single system reset. It also records which cause won. Power-on is an asynchronous input that restarts the controller at once. Brown-out and watchdog arrive as one-cycle event pulses. A debugger can post a reset request bit. The external reset pin is low-active and is filtered by a two-flop synchronizer followed by a low-length counter.

Any accepted cause runs the same sequence:
- one load cycle;
- a programmable timeout, during which the open-drain pad drive is enabled;
- an optional hold phase, which lasts while the external pin is still low;
- a two-read fetch of the reset vector from program addresses 0002h (high byte) and 0003h (low byte), followed by a program-counter load pulse.

Stop-mode recovery takes a much lighter path. A wake event in the stopped state holds only the CPU in reset for four clocks and requests the internal oscillator. It rewrites only the status flags, then runs the same vector fetch. The system reset and the pad drive stay inactive throughout.

Top module: `rstrec_ctrl`

## Requirements
- R1: The external pin passes through two synchronizer flops. A low lasting 4 or more clocks triggers a reset on the 6th rising edge after the pin fell. A low of 3 clocks or fewer is ignored, and the status bits stay unchanged.
- R2: If the pin is still low when the timeout ends, `sys_rst` stays high and `pad_drv_oe` is low until the pin rises. `sys_rst` then falls on the 3rd rising edge after the pin goes high.
- R3: For every cause, `sys_rst` stays high for exactly `tmo_cycles`+2 clocks when the pin is high. During that time `cpu_rst` is also high.
- R4: `pad_drv_oe` is high only during the load cycle and the timeout. It is never high without `sys_rst`.
- R5: Status bit positions are: bit0 power-on, bit1 brown-out, bit2 watchdog, bit3 external pin, bit4 debugger, bit5 stop recovery. Exactly one bit is set, and it marks the latest cause.
- R6: When causes coincide, the priority is power-on > brown-out > watchdog > external pin > debugger.
- R7: A `dbg_por_set` pulse sets `dbg_req` one clock later, and `dbg_req` triggers a reset on the next edge. Entering any system reset clears `dbg_req`.
- R8: `stop_req` in the running state enters stop. A `stop_wake` pulse in stop does all of the following:
  - holds `cpu_rst` high for exactly 4 clocks, with `osc_force_int` high for the same 4 clocks;
  - keeps `sys_rst` and `pad_drv_oe` low;
  - sets the status to 20h and sets `wdt_smr_flag`.
- R9: `stop_wake` has no effect outside the stopped state. `wdt_smr_flag` is cleared by any system reset.
- R10: After every release, `vec_rd` is high for two cycles: first with `vec_addr`=0002h, then with 0003h. On the next cycle `pc_load` pulses, and `pc` equals {data at 0002h, data at 0003h}.
- R11: `por_evt` resets the block asynchronously and holds `sys_rst` high while asserted. The status then reads 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (internal oscillator after stop recovery) |
| ext_pin_n | input | 1 | Level seen at the external reset pad, low-active |
| por_evt | input | 1 | Power-on detect, asynchronous, high-active |
| bor_evt | input | 1 | Brown-out event pulse |
| wdt_evt | input | 1 | Watchdog timeout pulse |
| dbg_por_set | input | 1 | Debugger write that posts a reset request |
| stop_req | input | 1 | CPU enters stop mode |
| stop_wake | input | 1 | Wake event while stopped |
| tmo_cycles | input | TMO_W | Reset timeout length in clocks |
| vec_data | input | DW | Program memory read data |
| sys_rst | output | 1 | Whole-chip reset |
| cpu_rst | output | 1 | CPU core reset |
| pad_drv_oe | output | 1 | Open-drain pad pull-down enable |
| osc_force_int | output | 1 | Force internal oscillator enabled and selected |
| rst_stat | output | 6 | One-hot reset cause flags |
| wdt_smr_flag | output | 1 | Watchdog-control reset flag set by stop recovery |
| dbg_req | output | 1 | Pending debugger reset request |
| vec_rd | output | 1 | Reset vector read strobe |
| vec_addr | output | AW | Reset vector read address |
| pc | output | 2*DW | Loaded program counter value |
| pc_load | output | 1 | Program counter load pulse |

## Verification
The hardest state to reach is the hold phase. The external pin must remain low after the programmed timeout has expired, and release must then be timed through the two synchronizer stages. The stimulus first uses a 4-clock pin low to trigger the external cause. It then keeps the pin low for well over the timeout, confirms that the pad drive has dropped while reset persists, and releases the pin at a known falling edge so the exact release edge can be counted.

Coinciding causes are reached in two ways. A debugger request is posted one cycle ahead of a watchdog pulse so both are present on the same edge. Power-on and brown-out are raised together.

// File: rtl/rstrec_ctrl.sv
module rstrec_ctrl #(
  parameter int TMO_W = 16,
  parameter int SMR_CYC = 4,
  parameter int EXT_MIN = 4,
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] VEC_ADDR = 16'h0002
) (
  input  logic             clk,
  input  logic             ext_pin_n,
  input  logic             por_evt,
  input  logic             bor_evt,
  input  logic             wdt_evt,
  input  logic             dbg_por_set,
  input  logic             stop_req,
  input  logic             stop_wake,
  input  logic [TMO_W-1:0] tmo_cycles,
  input  logic [DW-1:0]    vec_data,
  output logic             sys_rst,
  output logic             cpu_rst,
  output logic             pad_drv_oe,
  output logic             osc_force_int,
  output logic [5:0]       rst_stat,
  output logic             wdt_smr_flag,
  output logic             dbg_req,
  output logic             vec_rd,
  output logic [AW-1:0]    vec_addr,
  output logic [2*DW-1:0]  pc,
  output logic             pc_load
);
  localparam int SCW = (SMR_CYC > 1) ? $clog2(SMR_CYC) : 1;
  localparam int LCW = $clog2(EXT_MIN + 1);
  localparam logic [LCW-1:0] LO_TRIG = LCW'(EXT_MIN - 1);
  localparam logic [LCW-1:0] LO_SAT = LCW'(EXT_MIN);

  typedef enum logic [2:0] {
    S_LOAD, S_TMO, S_HOLD, S_VHI, S_VLO, S_RUN, S_STOP, S_SMR
  } st_t;

  st_t              state;
  logic [1:0]       pin_sync;
  logic [LCW-1:0]   lo_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic [SCW-1:0]   smr_cnt;

  wire       pin_lo   = !pin_sync[1];
  wire       ext_trig = pin_lo && (lo_cnt == LO_TRIG);
  wire       accept   = !(state inside {S_LOAD, S_TMO, S_HOLD});
  wire [5:0] src      = {1'b0, dbg_req, ext_trig, wdt_evt, bor_evt, 1'b0};
  wire [5:0] win      = src & (~src + 6'd1);

  assign sys_rst       = state inside {S_LOAD, S_TMO, S_HOLD};
  assign pad_drv_oe    = state inside {S_LOAD, S_TMO};
  assign cpu_rst       = sys_rst || (state == S_SMR);
  assign osc_force_int = (state == S_SMR);
  assign vec_rd        = state inside {S_VHI, S_VLO};
  assign vec_addr      = (state == S_VLO) ? VEC_ADDR + AW'(1) : VEC_ADDR;

  always_ff @(posedge clk or posedge por_evt) begin
    if (por_evt) begin
      state        <= S_LOAD;
      pin_sync     <= 2'b11;
      lo_cnt       <= '0;
      tmo_cnt      <= '0;
      smr_cnt      <= '0;
      rst_stat     <= 6'b000001;
      wdt_smr_flag <= 1'b0;
      dbg_req      <= 1'b0;
      pc           <= '0;
      pc_load      <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], ext_pin_n};
      lo_cnt   <= !pin_lo ? '0 : (lo_cnt == LO_SAT) ? lo_cnt : lo_cnt + LCW'(1);
      pc_load  <= (state == S_VLO);
      if (dbg_por_set) dbg_req <= 1'b1;
      if (accept && (|src)) begin
        state        <= S_LOAD;
        rst_stat     <= win;
        dbg_req      <= 1'b0;
        wdt_smr_flag <= 1'b0;
      end else begin
        case (state)
          S_LOAD: begin
            tmo_cnt <= tmo_cycles;
            state   <= S_TMO;
          end
          S_TMO: begin
            if (tmo_cnt != '0) tmo_cnt <= tmo_cnt - TMO_W'(1);
            else if (!pin_lo)  state <= S_VHI;
            else               state <= S_HOLD;
          end
          S_HOLD: if (!pin_lo) state <= S_VHI;
          S_VHI: begin
            pc[2*DW-1:DW] <= vec_data;
            state         <= S_VLO;
          end
          S_VLO: begin
            pc[DW-1:0] <= vec_data;
            state      <= S_RUN;
          end
          S_RUN: if (stop_req) state <= S_STOP;
          S_STOP: if (stop_wake) begin
            state        <= S_SMR;
            smr_cnt      <= SCW'(SMR_CYC - 1);
            rst_stat     <= 6'b100000;
            wdt_smr_flag <= 1'b1;
          end
          S_SMR: begin
            if (smr_cnt == '0) state <= S_VHI;
            else               smr_cnt <= smr_cnt - SCW'(1);
          end
          default: state <= S_LOAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/rstrec_ctrl_chk.sv
module rstrec_ctrl_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_ADDR = 16'h0002
) (
  input logic          clk,
  input logic          por_evt,
  input logic          sys_rst,
  input logic          cpu_rst,
  input logic          pad_drv_oe,
  input logic          osc_force_int,
  input logic [5:0]    rst_stat,
  input logic          dbg_req,
  input logic          vec_rd,
  input logic [AW-1:0] vec_addr,
  input logic          pc_load
);
  // R4
  oe_in_rst_chk: assert property (@(posedge clk) disable iff (por_evt)
    pad_drv_oe |-> sys_rst);
  // R3
  cpu_cover_chk: assert property (@(posedge clk) disable iff (por_evt)
    sys_rst |-> cpu_rst);
  // R8
  smr_quiet_chk: assert property (@(posedge clk) disable iff (por_evt)
    osc_force_int |-> (cpu_rst && !sys_rst && !pad_drv_oe));
  // R5
  stat_onehot_chk: assert property (@(posedge clk) disable iff (por_evt)
    $countones(rst_stat) == 1);
  // R7
  dbg_clr_chk: assert property (@(posedge clk) disable iff (por_evt)
    $rose(sys_rst) |-> !dbg_req);
  // R10
  vec_seq_chk: assert property (@(posedge clk) disable iff (por_evt)
    (vec_rd && vec_addr == VEC_ADDR) |=> (vec_rd && vec_addr == VEC_ADDR + AW'(1)));
  // R10
  pc_load_chk: assert property (@(posedge clk) disable iff (por_evt)
    pc_load |-> ($past(vec_rd) && !vec_rd && !cpu_rst));
endmodule

bind rstrec_ctrl rstrec_ctrl_chk #(.AW(AW), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .por_evt(por_evt), .sys_rst(sys_rst), .cpu_rst(cpu_rst),
  .pad_drv_oe(pad_drv_oe), .osc_force_int(osc_force_int), .rst_stat(rst_stat),
  .dbg_req(dbg_req), .vec_rd(vec_rd), .vec_addr(vec_addr), .pc_load(pc_load)
);

// File: tb/tb_rstrec_ctrl.sv
module tb_rstrec_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        ext_pin_n = 1'b1, por_evt = 1'b1, bor_evt = 1'b0, wdt_evt = 1'b0;
  logic        dbg_por_set = 1'b0, stop_req = 1'b0, stop_wake = 1'b0;
  logic [15:0] tmo_cycles = 16'd5;
  logic [7:0]  vec_data;
  logic        sys_rst, cpu_rst, pad_drv_oe, osc_force_int, wdt_smr_flag, dbg_req;
  logic        vec_rd, pc_load;
  logic [5:0]  rst_stat;
  logic [15:0] vec_addr, pc;
  logic [15:0] vec_word = 16'h1234;

  assign vec_data = (vec_addr == 16'h0002) ? vec_word[15:8] :
                    (vec_addr == 16'h0003) ? vec_word[7:0] : 8'h00;

  rstrec_ctrl dut (
    .clk(clk), .ext_pin_n(ext_pin_n), .por_evt(por_evt), .bor_evt(bor_evt),
    .wdt_evt(wdt_evt), .dbg_por_set(dbg_por_set), .stop_req(stop_req),
    .stop_wake(stop_wake), .tmo_cycles(tmo_cycles), .vec_data(vec_data),
    .sys_rst(sys_rst), .cpu_rst(cpu_rst), .pad_drv_oe(pad_drv_oe),
    .osc_force_int(osc_force_int), .rst_stat(rst_stat), .wdt_smr_flag(wdt_smr_flag),
    .dbg_req(dbg_req), .vec_rd(vec_rd), .vec_addr(vec_addr), .pc(pc), .pc_load(pc_load)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic count_rst(output int nr, output int noe);
    nr = 0; noe = 0;
    while (sys_rst && nr < 5000) begin
      nr++;
      if (pad_drv_oe) noe++;
      @(negedge clk);
    end
  endtask

  task automatic check_vec(string tag);
    chk({"R10 rd hi ", tag}, {31'd0, vec_rd}, 1);
    chk({"R10 addr hi ", tag}, vec_addr, 16'h0002);
    @(negedge clk);
    chk({"R10 addr lo ", tag}, vec_addr, 16'h0003);
    @(negedge clk);
    chk({"R10 pc_load ", tag}, {31'd0, pc_load}, 1);
    chk({"R10 pc ", tag}, pc, vec_word);
    @(negedge clk);
  endtask

  task automatic t_por();
    int nr, noe;
    vec_word = 16'hA53C;
    @(negedge clk);
    chk("R11 rst while por", {31'd0, sys_rst}, 1);
    por_evt = 1'b0;
    count_rst(nr, noe);
    chk("R3 por length", nr, 32'(tmo_cycles) + 2);
    chk("R4 por oe length", noe, 32'(tmo_cycles) + 2);
    chk("R11 por status", rst_stat, 6'h01);
    check_vec("por");
  endtask

  task automatic t_pulse_src(bit use_bor, logic [15:0] tmo, logic [5:0] st, logic [15:0] vw);
    int nr, noe;
    tmo_cycles = tmo; vec_word = vw;
    if (use_bor) bor_evt = 1'b1; else wdt_evt = 1'b1;
    @(negedge clk);
    bor_evt = 1'b0; wdt_evt = 1'b0;
    count_rst(nr, noe);
    chk("R3 pulse source length", nr, 32'(tmo) + 2);
    chk("R4 pulse source oe", noe, 32'(tmo) + 2);
    chk("R5 pulse source status", rst_stat, st);
    check_vec("pulse");
  endtask

  task automatic t_dbg();
    int nr, noe;
    tmo_cycles = 16'd5; vec_word = 16'h0F0E;
    dbg_por_set = 1'b1;
    @(negedge clk);
    dbg_por_set = 1'b0;
    chk("R7 request posted", {31'd0, dbg_req}, 1);
    chk("R7 not yet in reset", {31'd0, sys_rst}, 0);
    @(negedge clk);
    chk("R7 request self-clear", {31'd0, dbg_req}, 0);
    count_rst(nr, noe);
    chk("R3 debugger length", nr, 32'd7);
    chk("R5 debugger status", rst_stat, 6'h10);
    check_vec("dbg");
  endtask

  task automatic t_ext_short();
    ext_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_pin_n = 1'b1;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (sys_rst) seen = 1'b1;
      end
      chk("R1 3-clock pulse ignored", {31'd0, seen}, 0);
    end
    chk("R1 status untouched", rst_stat, 6'h10);
  endtask

  task automatic t_ext_four();
    int nr, noe;
    vec_word = 16'h7788;
    ext_pin_n = 1'b0;
    repeat (4) @(negedge clk);
    ext_pin_n = 1'b1;
    @(negedge clk);
    chk("R1 no reset before 6th edge", {31'd0, sys_rst}, 0);
    @(negedge clk);
    chk("R1 reset on 6th edge", {31'd0, sys_rst}, 1);
    count_rst(nr, noe);
    chk("R3 external length", nr, 32'(tmo_cycles) + 2);
    chk("R5 external status", rst_stat, 6'h08);
    check_vec("ext4");
  endtask

  task automatic t_ext_hold();
    int nr, noe;
    vec_word = 16'hBEEF;
    ext_pin_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2 still in reset", {31'd0, sys_rst}, 1);
    chk("R2 pad drive off in hold", {31'd0, pad_drv_oe}, 0);
    ext_pin_n = 1'b1;
    count_rst(nr, noe);
    chk("R2 release on 3rd edge", nr, 32'd3);
    chk("R2 external status", rst_stat, 6'h08);
    check_vec("hold");
  endtask

  task automatic t_prio();
    int nr, noe;
    bor_evt = 1'b1; wdt_evt = 1'b1;
    @(negedge clk);
    bor_evt = 1'b0; wdt_evt = 1'b0;
    count_rst(nr, noe);
    chk("R6 brown-out over watchdog", rst_stat, 6'h02);
    check_vec("p1");
    dbg_por_set = 1'b1;
    @(negedge clk);
    dbg_por_set = 1'b0; wdt_evt = 1'b1;
    @(negedge clk);
    wdt_evt = 1'b0;
    chk("R7 cleared by other source", {31'd0, dbg_req}, 0);
    count_rst(nr, noe);
    chk("R6 watchdog over debugger", rst_stat, 6'h04);
    check_vec("p2");
    por_evt = 1'b1; bor_evt = 1'b1;
    @(negedge clk);
    por_evt = 1'b0;
    @(negedge clk);
    bor_evt = 1'b0;
    count_rst(nr, noe);
    chk("R6 power-on over brown-out", rst_stat, 6'h01);
    check_vec("p3");
  endtask

  task automatic t_smr();
    int nc;
    bit bad;
    vec_word = 16'h4C21;
    stop_wake = 1'b1;
    @(negedge clk);
    stop_wake = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 wake ignored when running", {31'd0, cpu_rst}, 0);
    chk("R9 status kept", rst_stat, 6'h01);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (2) @(negedge clk);
    stop_wake = 1'b1;
    @(negedge clk);
    stop_wake = 1'b0;
    nc = 0; bad = 1'b0;
    while (cpu_rst && nc < 100) begin
      nc++;
      if (sys_rst || pad_drv_oe || !osc_force_int) bad = 1'b1;
      @(negedge clk);
    end
    chk("R8 cpu reset 4 clocks", nc, 32'd4);
    chk("R8 no system reset, osc forced", {31'd0, bad}, 0);
    chk("R8 stop status", rst_stat, 6'h20);
    chk("R8 wdt flag set", {31'd0, wdt_smr_flag}, 1);
    check_vec("smr");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset state status", rst_stat, 6'h01);
    chk("R4 pad drive in power-on", {31'd0, pad_drv_oe}, 1);
    t_por();
    t_smr();
    t_pulse_src(1'b0, 16'd0, 6'h04, 16'h1111);
    chk("R9 wdt flag cleared by reset", {31'd0, wdt_smr_flag}, 0);
    t_pulse_src(1'b1, 16'd12, 6'h02, 16'h2222);
    tmo_cycles = 16'd5;
    t_dbg();
    t_ext_short();
    t_ext_four();
    t_ext_hold();
    t_prio();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule